// File: doc/BRIEF.md
# Bang-Bang Duty Regulator with Counter-Compare PWM

This block closes a switching-converter control loop without any arithmetic on an error value. An external window comparator reports the converter output as two one-bit flags: `up_i` asks for more duty cycle and `down_i` asks for less. When both are low the output is inside the dead band. An integrating up/down counter holds the duty word D. It moves by one step at most once per switching period, at the period boundary, and it saturates at limits set by parameters. A counter-compare modulator reads D directly and drives the switch gate high for the first D clocks of every period of `PERIOD` clocks.

A synchronous load port overwrites D at once. A partner controller uses it to hand over its working duty value after it has been restarted. The loaded value is clamped into the legal window. During reset the gate output is held low.

Top module: `bbpwm_regulator`

## Requirements
- R1: The switching period is exactly `PERIOD` clocks. The first period starts at the first clock edge after reset is released, and every later period starts right after the previous one ends.
- R2: Within each period, `pwm_o` is high for the first D clocks and low for the rest, where D is the value of `duty_o` during that period. D = 0 keeps it low for the whole period, and D = `PERIOD` keeps it high for the whole period.
- R3: If `up_i` = 1 and `down_i` = 0 at the final clock of a period, D rises by one for the next period.
- R4: If `down_i` = 1 and `up_i` = 0 at the final clock of a period, D falls by one for the next period.
- R5: If both flags are 0 (dead band) at the final clock of a period, D keeps its value.
- R6: If both flags are 1 (illegal input) at the final clock of a period, D keeps its value.
- R7: Flag values at any clock other than the final clock of a period have no effect on D.
- R8: D never goes above `DUTY_MAX` or below `DUTY_MIN`. A step past a limit leaves D at that limit.
- R9: When `load_i` = 1 at a clock edge, D takes `load_val_i` clamped to [`DUTY_MIN`, `DUTY_MAX`] on that edge. This happens at any point in the period and takes priority over the flags.
- R10: While `rst_i` is high, `pwm_o` is 0 and D equals `DUTY_INIT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Comparator flag: output below window, raise duty |
| down_i | input | 1 | Comparator flag: output above window, lower duty |
| load_i | input | 1 | Overwrite the duty word on this edge |
| load_val_i | input | DUTY_W | Value to load (clamped into the limits) |
| pwm_o | output | 1 | Switch gate drive |
| duty_o | output | DUTY_W | Current duty word D |

## Verification
The bench uses `PERIOD` = 10 and `DUTY_W` = 4, so each period can be checked clock by clock against the rule that the gate is high only while the phase is below D. It builds two instances. The first has limits 0 and 10, which lets the duty word reach both the always-low and the always-high ends and lets an out-of-range load of 15 test the clamp. The second has limits 3 and 7, so saturation and load clamping are tested at limits that differ from the modulator's own ends.

// File: rtl/bbpwm_pkg.sv
`timescale 1ns/1ps
package bbpwm_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_RAISE = 2'b01,
        STEP_LOWER = 2'b10
    } step_e;

    // Dead band (00) and the illegal pair (11) both hold the duty word.
    function automatic step_e decode_flags(input logic raise, input logic lower);
        case ({raise, lower})
            2'b10:   return STEP_RAISE;
            2'b01:   return STEP_LOWER;
            default: return STEP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/bbpwm_period_timer.sv
`timescale 1ns/1ps
module bbpwm_period_timer #(
    parameter int PERIOD = 200,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             period_end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            // Parked on the last phase so the first edge after release opens phase 0.
            st_q.cnt <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_next_o   = st_d.cnt;
    assign period_end_o = (st_q.cnt == LAST);

endmodule

// File: rtl/bbpwm_duty_acc.sv
`timescale 1ns/1ps
module bbpwm_duty_acc
    import bbpwm_pkg::*;
#(
    parameter int DUTY_W    = 8,
    parameter int DUTY_MIN  = 0,
    parameter int DUTY_MAX  = 200,
    parameter int DUTY_INIT = 100
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              period_end_i,
    input  logic              up_i,
    input  logic              down_i,
    input  logic              load_i,
    input  logic [DUTY_W-1:0] load_val_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DUTY_W-1:0] duty_next_o
);
    localparam logic [DUTY_W-1:0] LIM_LO = DUTY_W'(DUTY_MIN);
    localparam logic [DUTY_W-1:0] LIM_HI = DUTY_W'(DUTY_MAX);
    localparam logic [DUTY_W-1:0] START  = DUTY_W'(DUTY_INIT);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } acc_t;

    acc_t  st_d, st_q;
    step_e step;
    logic  at_hi, at_lo;
    logic [DUTY_W-1:0] load_clamped;

    always_comb begin
        step  = decode_flags(up_i, down_i);
        at_hi = (int'(st_q.duty) >= DUTY_MAX);
        at_lo = (int'(st_q.duty) <= DUTY_MIN);

        if (int'(load_val_i) > DUTY_MAX) begin
            load_clamped = LIM_HI;
        end else if (int'(load_val_i) < DUTY_MIN) begin
            load_clamped = LIM_LO;
        end else begin
            load_clamped = load_val_i;
        end

        st_d = st_q;
        if (load_i) begin
            st_d.duty = load_clamped;
        end else if (period_end_i) begin
            unique case (step)
                STEP_RAISE: if (!at_hi) st_d.duty = st_q.duty + 1'b1;
                STEP_LOWER: if (!at_lo) st_d.duty = st_q.duty - 1'b1;
                default:    st_d.duty = st_q.duty;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.duty <= START;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_o      = st_q.duty;
    assign duty_next_o = st_d.duty;

endmodule

// File: rtl/bbpwm_modulator.sv
`timescale 1ns/1ps
module bbpwm_modulator #(
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DUTY_W-1:0] duty_next_i,
    input  logic [CNT_W-1:0]  cnt_next_i,
    output logic              pwm_o
);
    localparam int CMP_W = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;

    typedef struct packed {
        logic gate;
    } mod_t;

    mod_t st_d, st_q;
    logic [CMP_W-1:0] duty_x, phase_x;

    always_comb begin
        duty_x  = CMP_W'(duty_next_i);
        phase_x = CMP_W'(cnt_next_i);
        st_d    = st_q;
        // Gate is high while the phase is below the duty word.
        st_d.gate = (duty_x > phase_x);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.gate;

endmodule

// File: rtl/bbpwm_regulator.sv
`timescale 1ns/1ps
module bbpwm_regulator #(
    parameter int PERIOD    = 200,
    parameter int DUTY_W    = 8,
    parameter int DUTY_MIN  = 0,
    parameter int DUTY_MAX  = PERIOD,
    parameter int DUTY_INIT = PERIOD / 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              up_i,
    input  logic              down_i,
    input  logic              load_i,
    input  logic [DUTY_W-1:0] load_val_i,
    output logic              pwm_o,
    output logic [DUTY_W-1:0] duty_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0]  cnt_next;
    logic              period_end;
    logic [DUTY_W-1:0] duty_next;

    bbpwm_period_timer #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .cnt_next_o   (cnt_next),
        .period_end_o (period_end)
    );

    bbpwm_duty_acc #(
        .DUTY_W    (DUTY_W),
        .DUTY_MIN  (DUTY_MIN),
        .DUTY_MAX  (DUTY_MAX),
        .DUTY_INIT (DUTY_INIT)
    ) u_acc (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .period_end_i (period_end),
        .up_i         (up_i),
        .down_i       (down_i),
        .load_i       (load_i),
        .load_val_i   (load_val_i),
        .duty_o       (duty_o),
        .duty_next_o  (duty_next)
    );

    bbpwm_modulator #(
        .DUTY_W (DUTY_W),
        .CNT_W  (CNT_W)
    ) u_mod (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .duty_next_i (duty_next),
        .cnt_next_i  (cnt_next),
        .pwm_o       (pwm_o)
    );

endmodule

// File: rtl/bbpwm_regulator_chk.sv
`timescale 1ns/1ps
module bbpwm_regulator_chk #(
    parameter int PERIOD    = 200,
    parameter int DUTY_W    = 8,
    parameter int DUTY_MIN  = 0,
    parameter int DUTY_MAX  = PERIOD,
    parameter int DUTY_INIT = PERIOD / 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              up_i,
    input logic              down_i,
    input logic              load_i,
    input logic [DUTY_W-1:0] load_val_i,
    input logic              pwm_o,
    input logic [DUTY_W-1:0] duty_o,
    input logic              period_end_i
);
    function automatic int clip(input logic [DUTY_W-1:0] v);
        if (int'(v) > DUTY_MAX) return DUTY_MAX;
        if (int'(v) < DUTY_MIN) return DUTY_MIN;
        return int'(v);
    endfunction

    p_idle_low_r10: assert property (@(posedge clk_i)
        rst_i |=> (!pwm_o && int'(duty_o) == DUTY_INIT));

    p_zero_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (duty_o == '0) |-> !pwm_o);

    p_full_high_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(duty_o) == PERIOD && !$past(rst_i)) |-> pwm_o);

    p_deadband_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (period_end_i && !up_i && !down_i && !load_i) |=> $stable(duty_o));

    p_illegal_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (period_end_i && up_i && down_i && !load_i) |=> $stable(duty_o));

    p_mid_period_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!period_end_i && !load_i) |=> $stable(duty_o));

    p_in_limits_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(duty_o) >= DUTY_MIN) && (int'(duty_o) <= DUTY_MAX));

    p_load_value_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (int'(duty_o) == clip($past(load_val_i))));

endmodule

bind bbpwm_regulator bbpwm_regulator_chk #(
    .PERIOD    (PERIOD),
    .DUTY_W    (DUTY_W),
    .DUTY_MIN  (DUTY_MIN),
    .DUTY_MAX  (DUTY_MAX),
    .DUTY_INIT (DUTY_INIT)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .up_i         (up_i),
    .down_i       (down_i),
    .load_i       (load_i),
    .load_val_i   (load_val_i),
    .pwm_o        (pwm_o),
    .duty_o       (duty_o),
    .period_end_i (period_end)
);

// File: tb/bbpwm_regulator_bench.sv
`timescale 1ns/1ps
module bbpwm_regulator_bench;

    localparam int P     = 10;
    localparam int DW    = 4;
    localparam int B_MIN = 3;
    localparam int B_MAX = 7;
    localparam int INIT  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up = 1'b0, dn = 1'b0, ld = 1'b0;
    logic [DW-1:0] ldv = '0;
    logic pwm_a, pwm_b;
    logic [DW-1:0] duty_a, duty_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int dut_b  = INIT;

    always #5 clk = ~clk;

    bbpwm_regulator #(
        .PERIOD(P), .DUTY_W(DW), .DUTY_MIN(0), .DUTY_MAX(P), .DUTY_INIT(INIT)
    ) u_bbpwm_regulator (
        .clk_i(clk), .rst_i(rst), .up_i(up), .down_i(dn), .load_i(ld),
        .load_val_i(ldv), .pwm_o(pwm_a), .duty_o(duty_a)
    );

    bbpwm_regulator #(
        .PERIOD(P), .DUTY_W(DW), .DUTY_MIN(B_MIN), .DUTY_MAX(B_MAX), .DUTY_INIT(INIT)
    ) u_bbpwm_regulator_clip (
        .clk_i(clk), .rst_i(rst), .up_i(up), .down_i(dn), .load_i(ld),
        .load_val_i(ldv), .pwm_o(pwm_b), .duty_o(duty_b)
    );

    typedef struct packed {
        logic       f_up;
        logic       f_dn;
        logic       f_ld;
        logic [3:0] val;
        logic [3:0] hi;
        logic [3:0] nxt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd5,  4'd6,  4'd3},  // R3 raise
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd6,  4'd7,  4'd3},  // R3 raise
        '{1'b0, 1'b0, 1'b0, 4'd0,  4'd7,  4'd7,  4'd5},  // R5 dead band
        '{1'b1, 1'b1, 1'b0, 4'd0,  4'd7,  4'd7,  4'd6},  // R6 illegal pair
        '{1'b0, 1'b1, 1'b0, 4'd0,  4'd7,  4'd6,  4'd4},  // R4 lower
        '{1'b1, 1'b0, 1'b1, 4'd10, 4'd6,  4'd10, 4'd9},  // R9 load beats raise
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd10, 4'd10, 4'd8},  // R8 top limit, R2 full
        '{1'b0, 1'b0, 1'b1, 4'd0,  4'd10, 4'd0,  4'd9},  // R9 load zero
        '{1'b0, 1'b1, 1'b0, 4'd0,  4'd0,  4'd0,  4'd8},  // R8 bottom limit, R2 zero
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  4'd1,  4'd3},  // R3 leave zero
        '{1'b0, 1'b1, 1'b1, 4'd15, 4'd1,  4'd10, 4'd9},  // R9 clamp
        '{1'b0, 1'b0, 1'b0, 4'd0,  4'd10, 4'd10, 4'd2}   // R2 full period
    };

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clip_b(input int v);
        if (v > B_MAX) return B_MAX;
        if (v < B_MIN) return B_MIN;
        return v;
    endfunction

    // Starts at the negedge of phase 0. Body flags for phases 0..P-2, last flags
    // and optional load at phase P-1. Returns at phase 0 of the next period.
    task automatic run_period(input bit bu, input bit bd, input bit lu, input bit lds,
                              input bit do_ld, input int lval,
                              input int exp_hi_a, input int exp_nxt_a, input string req);
        int bad_a = 0, bad_b = 0, hi_b = dut_b;
        for (int i = 0; i < P; i++) begin
            if (i == P - 1) begin
                up = lu; dn = lds; ld = do_ld; ldv = DW'(lval);
            end else begin
                up = bu; dn = bd; ld = 1'b0;
            end
            #1;
            if (pwm_a !== (i < exp_hi_a)) bad_a++;
            if (pwm_b !== (i < hi_b))     bad_b++;
            @(negedge clk);
        end
        ld = 1'b0; up = 1'b0; dn = 1'b0;
        if (do_ld)           dut_b = clip_b(lval);
        else if (lu && !lds) dut_b = clip_b(dut_b + 1);
        else if (lds && !lu) dut_b = clip_b(dut_b - 1);
        #1;
        check(bad_a == 0, "R1/R2", bad_a, 0, "gate phases wrong (wide limits)");
        check(int'(duty_a) == exp_nxt_a, req, int'(duty_a), exp_nxt_a, "duty after boundary (wide)");
        check(bad_b == 0, "R1/R2", bad_b, 0, "gate phases wrong (narrow limits)");
        check(int'(duty_b) == dut_b, req, int'(duty_b), dut_b, "duty after boundary (narrow, R8)");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        check(pwm_a == 1'b0, "R10", int'(pwm_a), 0, "gate during reset");
        check(int'(duty_a) == INIT, "R10", int'(duty_a), INIT, "duty during reset");
        check(int'(duty_b) == INIT, "R10", int'(duty_b), INIT, "duty during reset (narrow)");
        rst = 1'b0;
        @(negedge clk);   // R1: first edge after release opens phase 0

        for (int k = 0; k < NV; k++) begin
            run_period(VEC[k].f_up, VEC[k].f_dn, VEC[k].f_up, VEC[k].f_dn, VEC[k].f_ld,
                       int'(VEC[k].val), int'(VEC[k].hi), int'(VEC[k].nxt),
                       $sformatf("R%0d", int'(VEC[k].req)));
        end

        // R7: lower flag during the body only, dropped on the last clock
        run_period(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 10, 10, "R7");
        // R7: raise flag during the body only (wide already at top)
        run_period(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 10, 10, "R7");
        // R4: lower flag on the last clock only
        run_period(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 10, 9, "R4");

        // R10: reset in the middle of a period restores the start state
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(pwm_a == 1'b0, "R10", int'(pwm_a), 0, "gate in mid-run reset");
        check(int'(duty_a) == INIT, "R10", int'(duty_a), INIT, "duty in mid-run reset");
        check(int'(duty_b) == INIT, "R10", int'(duty_b), INIT, "duty in mid-run reset (narrow)");
        dut_b = INIT;
        rst = 1'b0;
        @(negedge clk);
        run_period(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, INIT, INIT, "R1");

        done = 1;
        summary();
        $finish;
    end

endmodule